// File: doc/BRIEF.md
# Cascaded Three-Controller Interrupt Priority Unit

This block combines three eight-input priority controllers into one unit: a master and two slaves. Two master channels are cascade inputs, one per slave. Together they give 22 usable request levels. Each controller holds a pending-request register, an in-service register and a mask register. The unit resolves requests by fixed priority and drives a single interrupt line to the CPU.

Software configures the unit through a plain register write port. It can set masks, set trigger type per channel or per controller, issue non-specific end-of-interrupt (EOI) commands, and disable either slave. A disabled slave drops out of the chain, and one of its inputs is routed straight to its master cascade channel. With both slaves disabled the master runs alone and needs only one EOI per interrupt. The CPU acknowledges with a one-cycle `ack_i` pulse. One cycle later the unit reports which controller and channel was taken into service, or flags a spurious acknowledge.

The write port and the acknowledge pulse are control strobes with no back-pressure. Every write and every acknowledge takes effect at the clock edge where it is sampled.

Top module: `pic_cascade`

## Requirements
- R1: Reset clears all request, in-service and mask bits, enables both slaves, selects global edge mode on every controller, and holds `int_o` and `ack_vld_o` low.
- R2: In edge mode a channel request is latched on a rising input. It is lost if the input falls before acknowledge. An input still held high after acknowledge raises no new request.
- R3: In level mode the request follows the input level. A request still held high after its in-service bit is cleared by EOI raises `int_o` again.
- R4: When config bit 0 is 1, each channel uses its own trigger bit (1 = level), written at address 3 (master), 4 (slave 1) or 5 (slave 2). When config bit 0 is 0, config bits 1/2/3 (master/slave 1/slave 2, 1 = level) apply to all channels of that controller. The config register is at address 6.
- R5: A lower channel index has higher priority. Slave 1 feeds master channel 2 and slave 2 feeds master channel 5, so slave levels rank between the neighbouring master channels. A master cascade channel is level-sensitive while its slave is enabled.
- R6: A masked channel (mask registers at addresses 0/1/2, 1 = masked) keeps its pending request but does not drive `int_o`. Clearing the mask bit lets the request through.
- R7: A set in-service bit blocks requests of equal and lower priority on its controller. A higher-priority request still raises `int_o` and nests.
- R8: `ack_vld_o` pulses for one cycle, one cycle after `ack_i`. It carries `ack_src_o` (0 = master, 1 = slave 1, 2 = slave 2) and `ack_chan_o`. An acknowledge with no eligible request sets `ack_spur_o` and reports source 0, channel 7, and changes no state.
- R9: Writing address 7 with data[1:0] = controller id clears the highest-priority set in-service bit of that controller only. A cascaded interrupt needs an EOI to both the slave and the master.
- R10: Config bit 4 (bit 5) disables slave 1 (slave 2). A disabled slave 1 passes its input 3 to master channel 2, and a disabled slave 2 passes its input 5 to master channel 5. The other inputs of a disabled slave cannot raise `int_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_mst_i | input | N-2 | Master non-cascade inputs, bits in order of master channels 0,1,3,4,6,7 |
| irq_s1_i | input | N | Slave 1 channel inputs |
| irq_s2_i | input | N | Slave 2 channel inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | N | Register write data |
| ack_i | input | 1 | CPU acknowledge pulse |
| int_o | output | 1 | Interrupt request to CPU |
| ack_vld_o | output | 1 | Acknowledge result valid |
| ack_spur_o | output | 1 | Acknowledge found no eligible request |
| ack_src_o | output | 2 | Controller that supplied the serviced channel |
| ack_chan_o | output | log2(N) | Serviced channel number within that controller |

## Verification
The bench targets the orderings across the cascade. A slave request must beat a lower-priority master channel yet lose to master channels 0 and 1; a design that ranked by raw index would report the wrong source. It checks that an edge request dropped before acknowledge vanishes, and that a held edge input does not re-request after EOI. A design that confused the two trigger paths would issue duplicate or lost interrupts. It checks that an EOI to only the master leaves a lower slave request blocked, and that a disabled slave passes exactly one input. A design wired the wrong way would leak other slave inputs or lose the bypassed one.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam logic [2:0] ADDR_TRIG0 = 3'd3;
  localparam logic [2:0] ADDR_CFG   = 3'd6;
  localparam logic [2:0] ADDR_EOI   = 3'd7;
  localparam int NCTL = 3;
endpackage

// File: rtl/pic_regs.sv
module pic_regs import pic_pkg::*; #(
  parameter int N = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [2:0]               wr_addr_i,
  input  logic [N-1:0]             wr_data_i,
  output logic [NCTL-1:0][N-1:0]   mask_o,
  output logic [NCTL-1:0][N-1:0]   trig_o,
  output logic                     chan_mode_o,
  output logic [NCTL-1:0]          glob_lvl_o,
  output logic [1:0]               slv_dis_o,
  output logic [NCTL-1:0]          eoi_o
);
  logic [NCTL-1:0][N-1:0] mask_q, trig_q;
  logic                   mode_q;
  logic [NCTL-1:0]        glob_q;
  logic [1:0]             dis_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      trig_q <= '0;
      mode_q <= 1'b0;
      glob_q <= '0;
      dis_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i < ADDR_TRIG0)
        mask_q[wr_addr_i[1:0]] <= wr_data_i;
      else if (wr_addr_i < ADDR_CFG)
        trig_q[wr_addr_i - ADDR_TRIG0] <= wr_data_i;
      else if (wr_addr_i == ADDR_CFG) begin
        mode_q <= wr_data_i[0];
        glob_q <= wr_data_i[3:1];
        dis_q  <= wr_data_i[5:4];
      end
    end
  end

  generate
    for (genvar c = 0; c < NCTL; c++) begin : g_eoi
      assign eoi_o[c] = wr_en_i && (wr_addr_i == ADDR_EOI) && (wr_data_i[1:0] == 2'(c));
    end
  endgenerate

  assign mask_o      = mask_q;
  assign trig_o      = trig_q;
  assign chan_mode_o = mode_q;
  assign glob_lvl_o  = glob_q;
  assign slv_dis_o   = dis_q;
endmodule

// File: rtl/pic_unit.sv
module pic_unit #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0]         lvl_i,
  input  logic [N-1:0]         mask_i,
  input  logic                 ack_i,
  input  logic                 eoi_i,
  output logic                 int_o,
  output logic [$clog2(N)-1:0] win_o
);
  localparam int IW = $clog2(N);

  logic [N-1:0]  irr, isr, prev, pend, rise, ackbit, eoibit, irr_n;
  logic          pf, sf;
  logic [IW-1:0] pw, sw;

  always_comb begin
    pend = irr & ~mask_i;
    pf = 1'b0; pw = '0; sf = 1'b0; sw = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (pend[i]) begin pf = 1'b1; pw = IW'(i); end
      if (isr[i])  begin sf = 1'b1; sw = IW'(i); end
    end
    int_o = pf && (!sf || (pw < sw));
    ackbit = '0;
    if (ack_i && int_o) ackbit[pw] = 1'b1;
    eoibit = '0;
    if (eoi_i && sf) eoibit[sw] = 1'b1;
    rise = req_i & ~prev;
    for (int i = 0; i < N; i++)
      irr_n[i] = lvl_i[i] ? req_i[i]
                          : (req_i[i] & ((irr[i] & ~ackbit[i]) | rise[i]));
  end

  assign win_o = pw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr  <= '0;
      isr  <= '0;
      prev <= '0;
    end else begin
      irr  <= irr_n;
      isr  <= (isr & ~eoibit) | ackbit;
      prev <= req_i;
    end
  end

  p_req_needs_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~$past(req_i)) == '0);

  p_ack_to_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o) |=> isr[$past(win_o)]);

  p_eoi_clears_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !(ack_i && int_o) && isr != '0) |=>
      ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade import pic_pkg::*; #(
  parameter int N    = 8,
  parameter int CAS1 = 2,
  parameter int CAS2 = 5,
  parameter int BYP1 = 3,
  parameter int BYP2 = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-3:0]         irq_mst_i,
  input  logic [N-1:0]         irq_s1_i,
  input  logic [N-1:0]         irq_s2_i,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_addr_i,
  input  logic [N-1:0]         wr_data_i,
  input  logic                 ack_i,
  output logic                 int_o,
  output logic                 ack_vld_o,
  output logic                 ack_spur_o,
  output logic [1:0]           ack_src_o,
  output logic [$clog2(N)-1:0] ack_chan_o
);
  localparam int IW = $clog2(N);

  logic [NCTL-1:0][N-1:0]  mask, trig, req, lvl;
  logic                    chan_mode;
  logic [NCTL-1:0]         glob_lvl, eoi, uint, uack;
  logic [1:0]              slv_dis;
  logic [NCTL-1:0][IW-1:0] win;
  logic                    casc1, casc2, spur;

  pic_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .mask_o(mask), .trig_o(trig),
    .chan_mode_o(chan_mode), .glob_lvl_o(glob_lvl), .slv_dis_o(slv_dis),
    .eoi_o(eoi)
  );

  assign req[1] = irq_s1_i;
  assign req[2] = irq_s2_i;

  generate
    for (genvar c = 0; c < N; c++) begin : g_mreq
      if (c == CAS1) begin : g_c1
        assign req[0][c] = slv_dis[0] ? irq_s1_i[BYP1] : uint[1];
      end else if (c == CAS2) begin : g_c2
        assign req[0][c] = slv_dis[1] ? irq_s2_i[BYP2] : uint[2];
      end else begin : g_dir
        localparam int J = c - ((c > CAS1) ? 1 : 0) - ((c > CAS2) ? 1 : 0);
        assign req[0][c] = irq_mst_i[J];
      end
    end
    for (genvar u = 0; u < NCTL; u++) begin : g_unit
      pic_unit #(.N(N)) u_ctl (
        .clk(clk), .rst_n(rst_n), .req_i(req[u]), .lvl_i(lvl[u]),
        .mask_i(mask[u]), .ack_i(uack[u]), .eoi_i(eoi[u]),
        .int_o(uint[u]), .win_o(win[u])
      );
    end
  endgenerate

  always_comb begin
    for (int u = 0; u < NCTL; u++)
      lvl[u] = chan_mode ? trig[u] : {N{glob_lvl[u]}};
    if (!slv_dis[0]) lvl[0][CAS1] = 1'b1;
    if (!slv_dis[1]) lvl[0][CAS2] = 1'b1;
    casc1   = (win[0] == IW'(CAS1)) && !slv_dis[0];
    casc2   = (win[0] == IW'(CAS2)) && !slv_dis[1];
    spur    = !uint[0] || (casc1 && !uint[1]) || (casc2 && !uint[2]);
    uack[0] = ack_i && !spur;
    uack[1] = uack[0] && casc1;
    uack[2] = uack[0] && casc2;
  end

  assign int_o = uint[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_vld_o  <= 1'b0;
      ack_spur_o <= 1'b0;
      ack_src_o  <= '0;
      ack_chan_o <= '0;
    end else begin
      ack_vld_o  <= ack_i;
      ack_spur_o <= ack_i && spur;
      if (!ack_i) begin
        ack_src_o  <= '0;
        ack_chan_o <= '0;
      end else if (spur) begin
        ack_src_o  <= 2'd0;
        ack_chan_o <= IW'(N-1);
      end else if (casc1) begin
        ack_src_o  <= 2'd1;
        ack_chan_o <= win[1];
      end else if (casc2) begin
        ack_src_o  <= 2'd2;
        ack_chan_o <= win[2];
      end else begin
        ack_src_o  <= 2'd0;
        ack_chan_o <= win[0];
      end
    end
  end

  p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |=> (ack_vld_o && ack_spur_o));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o |-> $past(ack_i));

  p_bypass_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && slv_dis == 2'b11) |=> (ack_src_o == 2'd0));
endmodule

// File: tb/tb_pic_cascade.sv
`timescale 1ns/1ps
module tb_pic_cascade;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] irq_mst;
  logic [7:0] irq_s1, irq_s2;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       ack;
  logic       int_o, ack_vld, ack_spur;
  logic [1:0] ack_src;
  logic [2:0] ack_chan;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pic_cascade #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .irq_mst_i(irq_mst), .irq_s1_i(irq_s1),
    .irq_s2_i(irq_s2), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ack_i(ack), .int_o(int_o), .ack_vld_o(ack_vld),
    .ack_spur_o(ack_spur), .ack_src_o(ack_src), .ack_chan_o(ack_chan)
  );

  typedef struct packed {
    logic [5:0] m;
    logic [7:0] a;
    logic [7:0] b;
    logic [1:0] src;
    logic [2:0] ch;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{6'b000001, 8'h00, 8'h00, 2'd0, 3'd0},
    '{6'b000100, 8'h80, 8'h00, 2'd1, 3'd7},
    '{6'b000010, 8'h01, 8'h00, 2'd0, 3'd1},
    '{6'b000000, 8'h0C, 8'h01, 2'd1, 3'd2},
    '{6'b001000, 8'h00, 8'hF0, 2'd0, 3'd4},
    '{6'b100000, 8'h00, 8'h20, 2'd2, 3'd5},
    '{6'b000000, 8'h00, 8'h81, 2'd2, 3'd0},
    '{6'b110000, 8'h00, 8'h00, 2'd0, 3'd6},
    '{6'b000000, 8'h40, 8'h00, 2'd1, 3'd6},
    '{6'b100000, 8'h00, 8'h00, 2'd0, 3'd7}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ack(string req, int src, int ch);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    chk({req, " ack valid"}, ack_vld, 1);
    chk({req, " ack spurious"}, ack_spur, 0);
    chk({req, " ack source"}, ack_src, src);
    chk({req, " ack channel"}, ack_chan, ch);
    ack = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_mst = '0; irq_s1 = '0; irq_s2 = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 int after reset", int_o, 0);
    chk("R1 valid after reset", ack_vld, 0);

    // R8: spurious acknowledge
    @(negedge clk); ack = 1'b1;
    @(negedge clk);
    chk("R8 spurious valid", ack_vld, 1);
    chk("R8 spurious flag", ack_spur, 1);
    chk("R8 spurious channel", ack_chan, 7);
    ack = 1'b0;
    tick(1);
    chk("R8 valid one cycle", ack_vld, 0);

    // R5: priority table
    for (int i = 0; i < 10; i++) begin
      irq_mst = TBL[i].m; irq_s1 = TBL[i].a; irq_s2 = TBL[i].b;
      tick(4);
      chk("R5 int raised", int_o, 1);
      do_ack("R5", TBL[i].src, TBL[i].ch);
      irq_mst = '0; irq_s1 = '0; irq_s2 = '0;
      wr(3'd7, 8'd0);
      if (TBL[i].src != 0) wr(3'd7, {6'd0, TBL[i].src});
      tick(3);
      chk("R5 idle after service", int_o, 0);
    end

    // R2: edge drop before ack, no re-request when held
    irq_mst = 6'b000001; tick(2); irq_mst = '0; tick(3);
    chk("R2 dropped edge lost", int_o, 0);
    irq_mst = 6'b000001; tick(4);
    do_ack("R2", 0, 0);
    wr(3'd7, 8'd0); tick(4);
    chk("R2 held edge no re-request", int_o, 0);
    irq_mst = '0; tick(2);

    // R3: level mode on master
    wr(3'd6, 8'h02);
    irq_mst = 6'b000001; tick(4);
    do_ack("R3", 0, 0);
    tick(3);
    chk("R7 in-service blocks same", int_o, 0);
    wr(3'd7, 8'd0); tick(3);
    chk("R3 level re-request", int_o, 1);
    irq_mst = '0; tick(3);
    chk("R3 level follows input", int_o, 0);

    // R4: per-channel trigger selection
    wr(3'd3, 8'h02);
    wr(3'd6, 8'h01);
    irq_mst = 6'b000011; tick(4);
    do_ack("R4 ch0", 0, 0);
    wr(3'd7, 8'd0); tick(3);
    do_ack("R4 ch1", 0, 1);
    wr(3'd7, 8'd0); tick(3);
    chk("R4 level channel re-requests", int_o, 1);
    do_ack("R4 ch1 again", 0, 1);
    irq_mst = '0; wr(3'd7, 8'd0);
    wr(3'd6, 8'h00);
    irq_mst = 6'b000010; tick(4);
    do_ack("R4 global", 0, 1);
    wr(3'd7, 8'd0); tick(3);
    chk("R4 global edge fallback", int_o, 0);
    irq_mst = '0; tick(2);

    // R6: mask
    wr(3'd0, 8'h01);
    irq_mst = 6'b000001; tick(4);
    chk("R6 masked no int", int_o, 0);
    wr(3'd0, 8'h00); tick(3);
    chk("R6 unmask releases", int_o, 1);
    do_ack("R6", 0, 0);
    irq_mst = '0; wr(3'd7, 8'd0); tick(2);

    // R7 and R9: nesting and EOI order
    irq_mst = 6'b000100; tick(4);
    do_ack("R7 ch3", 0, 3);
    irq_mst = 6'b001000; tick(4);
    chk("R7 lower blocked", int_o, 0);
    irq_mst = 6'b001001; tick(4);
    chk("R7 higher nests", int_o, 1);
    do_ack("R7 ch0", 0, 0);
    irq_mst = 6'b001000;
    wr(3'd7, 8'd0); tick(3);
    chk("R9 EOI clears only highest", int_o, 0);
    wr(3'd7, 8'd0); tick(3);
    chk("R9 second EOI releases", int_o, 1);
    do_ack("R9 ch4", 0, 4);
    irq_mst = '0; wr(3'd7, 8'd0); tick(2);

    // R9: cascaded needs both EOIs
    irq_s1 = 8'h04; tick(4);
    do_ack("R9 s1", 1, 2);
    irq_s1 = '0; wr(3'd7, 8'd0);
    irq_s1 = 8'h20; tick(4);
    chk("R9 slave still in service", int_o, 0);
    wr(3'd7, 8'd1); tick(4);
    chk("R9 slave EOI releases", int_o, 1);
    do_ack("R9 s1 ch5", 1, 5);
    irq_s1 = '0; wr(3'd7, 8'd1); wr(3'd7, 8'd0); tick(2);

    // R10: bypass
    wr(3'd6, 8'h10);
    irq_s1 = 8'h01; tick(4);
    chk("R10 disabled slave other input", int_o, 0);
    irq_s1 = 8'h08; tick(4);
    chk("R10 bypass raises", int_o, 1);
    do_ack("R10 s1 bypass", 0, 2);
    irq_s1 = '0; wr(3'd7, 8'd0);
    wr(3'd6, 8'h30);
    irq_s2 = 8'h20; tick(4);
    do_ack("R10 s2 bypass", 0, 5);
    irq_s2 = '0; wr(3'd7, 8'd0); tick(2);

    // R1: reset restores defaults
    wr(3'd0, 8'hFF);
    @(negedge clk); rst_n = 1'b0;
    tick(2); rst_n = 1'b1;
    irq_s1 = 8'h02; tick(4);
    chk("R1 reset clears mask and enables slave", int_o, 1);
    do_ack("R1", 1, 1);
    irq_s1 = '0; tick(2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule